// File: doc/BRIEF.md
# Register-Mask Stack Push/Pull Sequencer

This block carries out the multi-register stack transfers of an 8-bit processor core. It receives an 8-bit selection mask and an operation code. Then, one byte per cycle, it pushes the selected registers to a stack held in byte-wide memory or pulls them back from it. Every byte access moves the stack pointer by one. The block can run on either of two stack pointers, the system pointer or the user pointer. When a transfer runs on one pointer, the mask slot that would name that same pointer names the other pointer instead.

A third operation performs the return-from-interrupt unstack. It always uses the system pointer. It first pulls the condition-code byte. Bit 7 of that byte (the "entire state saved" flag) then decides whether the whole saved frame comes back or only the program counter. The register file (CC, A, B, DP, X, Y, U, S, PC) lives inside the block. It is preset through a load port and observed through a read port. Instruction fetch and decode belong to the surrounding core.

Top module: `stk_mask_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `mem_we` and `mem_re` are low, and every register reads back as zero.
- R2: Mask bit 0 selects CC, bit 1 A, bit 2 B, bit 3 DP, bit 4 X, bit 5 Y and bit 7 PC. Bit 6 selects U when the transfer runs on S (`use_user`=0) and S when it runs on U (`use_user`=1).
- R3: A push (`op`=00) handles the selected registers from bit 7 down to bit 0. It writes each byte at the current pointer and then decrements the pointer. For a 16-bit register it writes the low byte first and the high byte second.
- R4: A pull (`op`=01) handles the selected registers from bit 0 up to bit 7. For each byte it first increments the pointer and then reads at the new value. For a 16-bit register it reads the high byte first.
- R5: `busy` rises in the cycle after a start is accepted. It stays high for 5 + 2×(selected 16-bit registers) + (selected 8-bit registers) cycles. `done` is high for exactly one cycle, the last busy cycle.
- R6: An all-zero mask completes after 5 busy cycles with no memory access and no change to either pointer.
- R7: A return (`op`=10) ignores `mask` and `use_user` and runs on S. It pulls CC first. If the pulled CC has bit 7 set, it then pulls A, B, DP, X, Y, U and PC (12 bytes, 17 cycles). Otherwise it pulls only PC (3 bytes, 8 cycles).
- R8: While `busy` is high, `start` and `ld_en` are ignored. The running transfer keeps its length, and no register takes the load value.
- R9: The load and read ports use these select codes: 0 CC, 1 A, 2 B, 3 DP, 4 X, 5 Y, 6 U, 7 S, 8 PC. An 8-bit register keeps only bits 7:0 of a loaded value. Select codes 9 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 00 push, 01 pull, 10 return unstack |
| use_user | input | 1 | 0 = run on S, 1 = run on U (push/pull only) |
| mask | input | 8 | Register selection mask |
| ld_en | input | 1 | Register load strobe (idle only) |
| ld_sel | input | 4 | Register select for load |
| ld_val | input | 16 | Load value |
| rd_sel | input | 4 | Register select for read-back |
| rd_val | output | 16 | Selected register value |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two register-file writes can land in one cycle. The first case is a pull that fills the other stack pointer while the active pointer steps. The full mask sweep on both pointers exercises this, and each pull is judged by comparing every register with an arithmetic model of the saved frame. The second case is an outside load or start request that arrives mid-transfer, while the sequencer owns the registers. To provoke it, the bench pulses `ld_en` on A together with a fresh `start` during a push. The result is judged by the unchanged cycle count, the unchanged A value, and the absence of any follow-on operation.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int MASK_W  = 8;
  localparam int REG_CNT = 9;

  localparam logic [3:0] RID_CC = 4'd0;
  localparam logic [3:0] RID_A  = 4'd1;
  localparam logic [3:0] RID_B  = 4'd2;
  localparam logic [3:0] RID_DP = 4'd3;
  localparam logic [3:0] RID_X  = 4'd4;
  localparam logic [3:0] RID_Y  = 4'd5;
  localparam logic [3:0] RID_U  = 4'd6;
  localparam logic [3:0] RID_S  = 4'd7;
  localparam logic [3:0] RID_PC = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_XFER, ST_FIN} seq_state_e;

  // mask bit position -> register id; slot 6 names the stack not in use
  function automatic logic [3:0] bit_to_rid(input logic [2:0] b, input logic user_stk);
    case (b)
      3'd7:    return RID_PC;
      3'd6:    return user_stk ? RID_S : RID_U;
      default: return {1'b0, b};
    endcase
  endfunction

  function automatic logic rid_wide(input logic [3:0] r);
    return (r >= RID_X) && (r <= RID_PC);
  endfunction

  function automatic logic [2:0] hot_to_idx(input logic [MASK_W-1:0] h);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (h[i]) r = 3'(i);
    return r;
  endfunction

  // registers still to pull after CC during a return, from the E flag
  function automatic logic [MASK_W-1:0] rti_tail_mask(input logic e_flag);
    return e_flag ? 8'hFE : 8'h80;
  endfunction

endpackage

// File: rtl/stk_pick.sv
module stk_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  input  logic         from_top,
  output logic [W-1:0] hot
);
  logic [W:0]   seen_lo;  // seen_lo[i]: any bit below i set
  logic [W:0]   seen_hi;  // seen_hi[i]: any bit at or above i set
  logic [W-1:0] lo_hot;
  logic [W-1:0] hi_hot;

  assign seen_lo[0] = 1'b0;
  assign seen_hi[W] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_scan
    assign seen_lo[g+1] = seen_lo[g] | vec[g];
    assign seen_hi[g]   = seen_hi[g+1] | vec[g];
    assign lo_hot[g]    = vec[g] & ~seen_lo[g];
    assign hi_hot[g]    = vec[g] & ~seen_hi[g+1];
  end

  assign hot = from_top ? hi_hot : lo_hot;
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [3:0]        ld_sel,
  input  logic [WORD_W-1:0] ld_val,
  input  logic              bw_en,
  input  logic [3:0]        bw_sel,
  input  logic              bw_hi,
  input  logic [BYTE_W-1:0] bw_data,
  input  logic              sp_en,
  input  logic              sp_user,
  input  logic [WORD_W-1:0] sp_val,
  input  logic [3:0]        rd_sel,
  output logic [WORD_W-1:0] rd_val,
  input  logic [3:0]        src_sel,
  output logic [WORD_W-1:0] src_val,
  output logic [WORD_W-1:0] sp_cur
);
  logic [REG_CNT-1:0][WORD_W-1:0] regs;
  logic [3:0] sp_id;

  assign sp_id = sp_user ? RID_U : RID_S;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    localparam logic [3:0] ID = 4'(g);
    localparam bit WIDE = (g >= 4);
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld_en && ld_sel == ID) begin
        q <= WIDE ? ld_val : {8'h00, ld_val[7:0]};
      end else begin
        if (bw_en && bw_sel == ID) begin
          if (bw_hi) q[15:8] <= bw_data;
          else       q[7:0]  <= bw_data;
        end
        if (sp_en && sp_id == ID) q <= sp_val;
      end
    end
    assign regs[g] = q;
  end

  always_comb begin
    rd_val  = '0;
    src_val = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if (rd_sel == 4'(i))  rd_val  = regs[i];
      if (src_sel == 4'(i)) src_val = regs[i];
    end
  end

  assign sp_cur = sp_user ? regs[RID_U] : regs[RID_S];
endmodule

// File: rtl/stk_mask_seq.sv
module stk_mask_seq
  import stk_pkg::*;
#(
  parameter int BASE_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              use_user,
  input  logic [MASK_W-1:0] mask,
  input  logic              ld_en,
  input  logic [3:0]        ld_sel,
  input  logic [WORD_W-1:0] ld_val,
  input  logic [3:0]        rd_sel,
  output logic [WORD_W-1:0] rd_val,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done
);
  localparam int PRE_CYC = BASE_CYC - 1;
  localparam int CNT_W   = $clog2(BASE_CYC + 1);

  seq_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [MASK_W-1:0] pend;
  logic              is_pull, is_rti, on_user, second;

  // named internal events
  logic              idle_w, xfer_w, accept_w, byte_last_w, rti_expand_w;
  logic [MASK_W-1:0] hot, pend_after;
  logic [2:0]        cur_bit;
  logic [3:0]        cur_rid;
  logic              cur_wide;
  logic [WORD_W-1:0] src_val, sp_cur, sp_next;

  assign idle_w   = (st == ST_IDLE);
  assign xfer_w   = (st == ST_XFER);
  assign accept_w = idle_w && start;

  stk_pick #(.W(MASK_W)) u_pick (
    .vec      (pend),
    .from_top (~is_pull),
    .hot      (hot)
  );

  assign cur_bit     = hot_to_idx(hot);
  assign cur_rid     = bit_to_rid(cur_bit, on_user);
  assign cur_wide    = rid_wide(cur_rid);
  assign byte_last_w = ~cur_wide | second;
  assign sp_next     = is_pull ? sp_cur + 16'd1 : sp_cur - 16'd1;

  stk_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en && idle_w),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .bw_en   (xfer_w && is_pull),
    .bw_sel  (cur_rid),
    .bw_hi   (cur_wide && !second),
    .bw_data (mem_rdata),
    .sp_en   (xfer_w),
    .sp_user (on_user),
    .sp_val  (sp_next),
    .rd_sel  (rd_sel),
    .rd_val  (rd_val),
    .src_sel (cur_rid),
    .src_val (src_val),
    .sp_cur  (sp_cur)
  );

  assign mem_addr  = is_pull ? sp_cur + 16'd1 : sp_cur;
  assign mem_we    = xfer_w && !is_pull;
  assign mem_re    = xfer_w && is_pull;
  assign mem_wdata = second ? src_val[15:8] : src_val[7:0];

  assign rti_expand_w = xfer_w && is_rti && byte_last_w && hot[0];

  always_comb begin
    pend_after = pend;
    if (byte_last_w) pend_after = pend & ~hot;
    if (rti_expand_w) pend_after = rti_tail_mask(mem_rdata[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      pend    <= '0;
      is_pull <= 1'b0;
      is_rti  <= 1'b0;
      on_user <= 1'b0;
      second  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept_w) begin
          st      <= ST_PRE;
          cnt     <= CNT_W'(PRE_CYC - 1);
          is_rti  <= op[1];
          is_pull <= op[1] | op[0];
          on_user <= ~op[1] & use_user;
          pend    <= op[1] ? 8'h01 : mask;
          second  <= 1'b0;
        end
        ST_PRE: begin
          if (cnt == '0) st <= (pend != '0) ? ST_XFER : ST_FIN;
          else           cnt <= cnt - 1'b1;
        end
        ST_XFER: begin
          second <= ~byte_last_w;
          pend   <= pend_after;
          if (pend_after == '0) st <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = !idle_w;
  assign done = (st == ST_FIN);

  // R3 R4: each transfer cycle serves exactly one mask slot
  assert_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |-> $countones(hot) == 1);

  // R3: push moves the active pointer down by one per byte
  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w && !is_pull) |=> sp_cur == $past(sp_cur) - 16'd1);

  // R4: pull moves the active pointer up by one per byte
  assert_pull_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w && is_pull) |=> sp_cur == $past(sp_cur) + 16'd1);

  // R5: done lasts one cycle and ends the operation
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8: an operation in flight cannot be cut short by start
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R6: the prelude never touches memory
  assert_pre_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |-> !(mem_we || mem_re));
endmodule

// File: tb/stk_mask_seq_bench.sv
module stk_mask_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, use_user, ld_en, mem_we, mem_re, busy, done;
  logic [1:0]  op;
  logic [7:0]  mask, mem_wdata, mem_rdata;
  logic [3:0]  ld_sel, rd_sel;
  logic [15:0] ld_val, rd_val, mem_addr;

  always #5 clk = ~clk;

  stk_mask_seq u_stk_mask_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_user(use_user),
    .mask(mask), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .rd_sel(rd_sel), .rd_val(rd_val), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] mdl [0:8];
  logic [15:0] ex_addr [0:31];
  logic        ex_we   [0:31];
  logic [7:0]  ex_dat  [0:31];
  int          ex_n, ex_cyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rid_of(input int b, input bit onu);
    if (b == 7) return 8;
    if (b == 6) return onu ? 7 : 6;
    return b;
  endfunction

  task automatic add_ex(input logic [15:0] a, input bit we, input logic [7:0] d);
    ex_addr[ex_n] = a; ex_we[ex_n] = we; ex_dat[ex_n] = d; ex_n++;
  endtask

  // independent model of one operation; updates mdl and the expected access list
  task automatic model_op(input logic [1:0] o, input bit onu_in, input logic [7:0] m_in);
    bit onu; bit pull; logic [7:0] m; int spi; logic [15:0] sp; logic [7:0] hi, lo;
    onu = (o == 2'b10) ? 1'b0 : onu_in;
    pull = (o != 2'b00);
    spi = onu ? 6 : 7;
    sp = mdl[spi];
    m = m_in;
    if (o == 2'b10) m = mem[8'(sp + 16'd1)][7] ? 8'hFF : 8'h81;
    ex_n = 0;
    if (!pull) begin
      for (int b = 7; b >= 0; b--) if (m[b]) begin
        int r; r = rid_of(b, onu);
        if (r >= 4) begin
          add_ex(sp, 1'b1, mdl[r][7:0]);  sp = sp - 16'd1;
          add_ex(sp, 1'b1, mdl[r][15:8]); sp = sp - 16'd1;
        end else begin
          add_ex(sp, 1'b1, mdl[r][7:0]);  sp = sp - 16'd1;
        end
      end
    end else begin
      for (int b = 0; b < 8; b++) if (m[b]) begin
        int r; r = rid_of(b, onu);
        if (r >= 4) begin
          sp = sp + 16'd1; hi = mem[sp[7:0]]; add_ex(sp, 1'b0, 8'h00);
          sp = sp + 16'd1; lo = mem[sp[7:0]]; add_ex(sp, 1'b0, 8'h00);
          mdl[r] = {hi, lo};
        end else begin
          sp = sp + 16'd1; add_ex(sp, 1'b0, 8'h00);
          mdl[r] = {8'h00, mem[sp[7:0]]};
        end
      end
    end
    mdl[spi] = sp;
    ex_cyc = 5 + ex_n;
  endtask

  task automatic load(input int r, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 4'(r); ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[r] = (r >= 4) ? v : {8'h00, v[7:0]};
  endtask

  task automatic check_regs(input string req);
    bit ok; int first;
    ok = 1; first = 0;
    for (int r = 0; r < 9; r++) begin
      rd_sel = 4'(r); #1;
      if (ok && rd_val !== mdl[r]) begin ok = 0; first = r; end
    end
    rd_sel = 4'(first); #1;
    chk(ok, req, $sformatf("register %0d", first), rd_val, mdl[first]);
  endtask

  task automatic run(input logic [1:0] o, input bit onu, input logic [7:0] m,
                     input string req, input bit disturb);
    int cyc, dn, dpos, obn; bit ok; int bad_i;
    logic [15:0] ob_addr [0:31]; logic ob_we [0:31]; logic [7:0] ob_dat [0:31];
    model_op(o, onu, m);
    @(negedge clk);
    start = 1'b1; op = o; use_user = onu; mask = m;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; dn = 0; dpos = 0; obn = 0;
    while (busy && cyc < 64) begin
      cyc++;
      if (done) begin dn++; dpos = cyc; end
      if (mem_we || mem_re) begin
        if (obn < 32) begin
          ob_addr[obn] = mem_addr; ob_we[obn] = mem_we; ob_dat[obn] = mem_wdata;
        end
        obn++;
      end
      @(negedge clk);
      if (disturb && cyc == 2) begin
        start = 1'b1; op = 2'b01; mask = 8'hFF; use_user = 1'b1;
        ld_en = 1'b1; ld_sel = 4'd1; ld_val = 16'h0077;
      end else if (disturb && cyc == 3) begin
        start = 1'b0; ld_en = 1'b0;
      end
    end
    chk(cyc == ex_cyc, "R5", "busy cycles", cyc, ex_cyc);
    chk(dn == 1 && dpos == cyc, "R5", "done position", dpos, cyc);
    chk(obn == ex_n, req, "access count", obn, ex_n);
    ok = 1; bad_i = 0;
    for (int i = 0; i < ex_n && i < obn; i++) begin
      if (ok && (ob_addr[i] !== ex_addr[i] || ob_we[i] !== ex_we[i] ||
                 (ex_we[i] && ob_dat[i] !== ex_dat[i]))) begin
        ok = 0; bad_i = i;
      end
    end
    chk(ok, req, $sformatf("access %0d addr", bad_i), ob_addr[bad_i], ex_addr[bad_i]);
    check_regs(req);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; op = 0; use_user = 0; mask = 0;
    ld_en = 0; ld_sel = 0; ld_val = 0; rd_sel = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int r = 0; r < 9; r++) mdl[r] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_we && !mem_re, "R1", "idle outputs",
        {busy, done, mem_we, mem_re}, 0);
    check_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R9: narrow load and unused selects
    load(1, 16'hABCD);
    rd_sel = 4'd1; #1;
    chk(rd_val === 16'h00CD, "R9", "narrow load", rd_val, 16'h00CD);
    for (int s = 9; s < 16; s++) begin
      rd_sel = 4'(s); #1;
      chk(rd_val === 16'h0000, "R9", $sformatf("select %0d", s), rd_val, 0);
    end

    // R6: empty mask on both stacks
    load(7, 16'h0080); load(6, 16'h00C0);
    run(2'b00, 1'b0, 8'h00, "R6", 1'b0);
    run(2'b01, 1'b1, 8'h00, "R6", 1'b0);

    // R3 R4: full sweep of masks on both stacks, push then pull back
    for (int u = 0; u < 2; u++) begin
      for (int m = 0; m < 256; m++) begin
        for (int r = 0; r < 6; r++)
          load(r, 16'(m * 16'h0101 ^ r * 16'h1111 ^ u * 16'h5A5A));
        load(8, 16'(16'hC000 + m));
        load(7, 16'h0080); load(6, 16'h00C0);
        run(2'b00, 1'(u), 8'(m), "R3", 1'b0);
        run(2'b01, 1'(u), 8'(m), "R4", 1'b0);
        // R2: pull of untouched data on U, slot 6 naming S
        if (u == 1 && (m % 8) == 5) begin
          load(6, 16'h0040);
          run(2'b01, 1'b1, 8'(m), "R2", 1'b0);
        end
      end
    end

    // R7: return unstack, E flag set and clear
    mem[8'h41] = 8'h8A;
    load(7, 16'h0040);
    run(2'b10, 1'b0, 8'h00, "R7", 1'b0);
    mem[8'h41] = 8'h05;
    load(7, 16'h0040); load(6, 16'h00C0);
    run(2'b10, 1'b1, 8'hFF, "R7", 1'b0);

    // R8: start and load during a transfer
    load(7, 16'h0080); load(1, 16'h0012);
    run(2'b00, 1'b0, 8'h06, "R8", 1'b1);
    @(negedge clk); @(negedge clk);
    chk(!busy, "R8", "no queued operation", busy, 0);
    rd_sel = 4'd1; #1;
    chk(rd_val === 16'h0012, "R8", "A after blocked load", rd_val, 16'h0012);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule